// File: doc/BRIEF.md
# Phase build-out offset controller

This block sits on the phase-error path of a digital PLL, between the phase detector and the loop filter. Each clock it takes a signed phase-error sample, removes a stored build-out offset from it, adds a small correction term and hands the saturated result to the loop filter one cycle later. When the loop changes its reference source, the error seen at that moment is captured as the new stored offset. The loop then keeps its output phase instead of slewing to the new reference's phase.

Captures come from a switch strobe, or from turning build-out on while the loop is locked. A freeze control holds the stored offset and blocks further captures. When build-out is switched off while locked, the stored offset is walked back to zero in fixed steps, so the loop returns to zero phase error gradually. When it is switched off while unlocked, the offset is cleared at once. With build-out on, a programmable static offset is added. With both build-out and freeze off, a wider fine input-to-output trim is added instead.

All phase quantities share one LSB of 1 ps by default. The static step is 101 LSB and the fine step is 6 LSB.

Top module: `pbo_ctrl`

## Requirements
- R1: During and after reset, `offset_o`, `corr_err_o` and `capture_o` are all zero until the first capture or input-driven update.
- R2: With enable set and freeze clear, a strobe on `switch_evt_i` in cycle N causes, from cycle N+2, `offset_o` to equal the `phase_err_i` sample of cycle N+1. `capture_o` is high for exactly cycle N+2.
- R3: While enable and freeze are both set, `offset_o` keeps its value and switch strobes produce no capture.
- R4: A 0-to-1 change of `pbo_en_i` while `locked_i` is high acts as a switch event (capture two cycles later). The same change while unlocked causes no capture.
- R5: While enable is clear and `locked_i` is high, `offset_o` moves toward zero by `DECAY_STEP` each cycle. It becomes zero once its magnitude is at most `DECAY_STEP`.
- R6: While enable is clear and `locked_i` is low, `offset_o` becomes zero on the next cycle.
- R7: `corr_err_o` in cycle N+1 equals `phase_err_i` minus `offset_o` plus a correction term, all taken in cycle N. With enable set, the term is the static code times 101.
- R8: `static_ofs_i` is a 5-bit two's-complement code. Values below -14 are used as -14 and values above +14 as +14.
- R9: `fine_adj_i` is a 16-bit two's-complement code. It adds code times 6 to the correction only when enable and freeze are both clear; otherwise it has no effect on `corr_err_o`.
- R10: `corr_err_o` saturates to the 24-bit signed range instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_err_i | input | 24 | Signed phase-error sample from the detector |
| switch_evt_i | input | 1 | One-cycle strobe on a reference switch |
| locked_i | input | 1 | Loop is in the locked state |
| pbo_en_i | input | 1 | Build-out enable |
| pbo_freeze_i | input | 1 | Hold stored offset, ignore switch events |
| static_ofs_i | input | 5 | Signed static offset code, 101 LSB per step |
| fine_adj_i | input | 16 | Signed fine trim code, 6 LSB per step |
| corr_err_o | output | 24 | Corrected, saturated phase error (registered) |
| offset_o | output | 24 | Stored build-out offset |
| capture_o | output | 1 | One-cycle pulse when a capture takes place |

## Verification
The hardest state to reach is a gradual return to zero that is cut short. Build-out has to be dropped while locked with a large stored offset, and then the lock has to be lost mid-walk, so that the stepped decay switches to an immediate clear. Random stimulus toggles enable, lock and freeze rarely and independently while switch strobes are frequent, so long decays build up and get interrupted. Directed sequences cover the enable-while-locked capture, the static code clamp and both saturation rails.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  typedef enum logic [1:0] {
    TERM_NONE   = 2'd0,
    TERM_STATIC = 2'd1,
    TERM_FINE   = 2'd2
  } term_sel_e;
endpackage

// File: rtl/pbo_evt.sv
module pbo_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic switch_evt_i,
  input  logic locked_i,
  input  logic en_i,
  input  logic freeze_i,
  output logic pend_o
);
  logic en_q;
  logic en_rise;
  logic evt;

  assign en_rise = en_i && !en_q && locked_i;
  assign evt     = !freeze_i && ((switch_evt_i && en_i) || en_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      en_q   <= en_i;
      pend_o <= evt;
    end
  end
endmodule

// File: rtl/pbo_store.sv
module pbo_store #(
  parameter int W          = 24,
  parameter int DECAY_STEP = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                locked_i,
  input  logic                freeze_i,
  input  logic                pend_i,
  input  logic signed [W-1:0] err_i,
  output logic signed [W-1:0] offset_o,
  output logic                cap_o
);
  localparam logic signed [W-1:0] STEP_P = W'(DECAY_STEP);
  localparam logic signed [W-1:0] STEP_N = -STEP_P;

  logic signed [W-1:0] toward_zero;
  logic signed [W-1:0] off_d;
  logic                take;

  always_comb begin
    if (offset_o > STEP_P)      toward_zero = offset_o - STEP_P;
    else if (offset_o < STEP_N) toward_zero = offset_o + STEP_P;
    else                        toward_zero = '0;
  end

  assign take = en_i && pend_i && !freeze_i;

  always_comb begin
    if (!en_i)     off_d = locked_i ? toward_zero : '0;
    else if (take) off_d = err_i;
    else           off_d = offset_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o <= '0;
      cap_o    <= 1'b0;
    end else begin
      offset_o <= off_d;
      cap_o    <= take;
    end
  end
endmodule

// File: rtl/pbo_sum.sv
module pbo_sum
  import pbo_pkg::*;
#(
  parameter int W           = 24,
  parameter int SW          = 5,
  parameter int FW          = 16,
  parameter int STATIC_LIM  = 14,
  parameter int STATIC_STEP = 101,
  parameter int FINE_STEP   = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [W-1:0]  err_i,
  input  logic signed [W-1:0]  offset_i,
  input  logic                 en_i,
  input  logic                 freeze_i,
  input  logic signed [SW-1:0] static_i,
  input  logic signed [FW-1:0] fine_i,
  output logic signed [W-1:0]  corr_o
);
  localparam int XW = W + 3;
  localparam logic signed [XW-1:0] MAXV = {{(XW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {{(XW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [XW-1:0] LIM_P = XW'(STATIC_LIM);
  localparam logic signed [XW-1:0] LIM_N = -LIM_P;

  term_sel_e           sel;
  logic signed [XW-1:0] st_x;
  logic signed [XW-1:0] st_lim;
  logic signed [XW-1:0] term;
  logic signed [XW-1:0] sum;
  logic signed [W-1:0]  sat;

  assign sel  = en_i ? TERM_STATIC : (freeze_i ? TERM_NONE : TERM_FINE);
  assign st_x = XW'(static_i);

  always_comb begin
    if (st_x > LIM_P)      st_lim = LIM_P;
    else if (st_x < LIM_N) st_lim = LIM_N;
    else                   st_lim = st_x;
  end

  always_comb begin
    unique case (sel)
      TERM_STATIC: term = st_lim * $signed(XW'(STATIC_STEP));
      TERM_FINE:   term = XW'(fine_i) * $signed(XW'(FINE_STEP));
      default:     term = '0;
    endcase
  end

  assign sum = XW'(err_i) - XW'(offset_i) + term;

  always_comb begin
    if (sum > MAXV)      sat = MAXV[W-1:0];
    else if (sum < MINV) sat = MINV[W-1:0];
    else                 sat = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) corr_o <= '0;
    else         corr_o <= sat;
  end
endmodule

// File: rtl/pbo_ctrl.sv
module pbo_ctrl #(
  parameter int W           = 24,
  parameter int SW          = 5,
  parameter int FW          = 16,
  parameter int STATIC_LIM  = 14,
  parameter int STATIC_STEP = 101,
  parameter int FINE_STEP   = 6,
  parameter int DECAY_STEP  = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [W-1:0]  phase_err_i,
  input  logic                 switch_evt_i,
  input  logic                 locked_i,
  input  logic                 pbo_en_i,
  input  logic                 pbo_freeze_i,
  input  logic signed [SW-1:0] static_ofs_i,
  input  logic signed [FW-1:0] fine_adj_i,
  output logic signed [W-1:0]  corr_err_o,
  output logic signed [W-1:0]  offset_o,
  output logic                 capture_o
);
  logic pend;

  pbo_evt u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .switch_evt_i(switch_evt_i),
    .locked_i    (locked_i),
    .en_i        (pbo_en_i),
    .freeze_i    (pbo_freeze_i),
    .pend_o      (pend)
  );

  pbo_store #(.W(W), .DECAY_STEP(DECAY_STEP)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pbo_en_i),
    .locked_i(locked_i),
    .freeze_i(pbo_freeze_i),
    .pend_i  (pend),
    .err_i   (phase_err_i),
    .offset_o(offset_o),
    .cap_o   (capture_o)
  );

  pbo_sum #(
    .W(W), .SW(SW), .FW(FW), .STATIC_LIM(STATIC_LIM),
    .STATIC_STEP(STATIC_STEP), .FINE_STEP(FINE_STEP)
  ) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (phase_err_i),
    .offset_i(offset_o),
    .en_i    (pbo_en_i),
    .freeze_i(pbo_freeze_i),
    .static_i(static_ofs_i),
    .fine_i  (fine_adj_i),
    .corr_o  (corr_err_o)
  );
endmodule

// File: rtl/pbo_ctrl_chk.sv
module pbo_ctrl_chk #(
  parameter int W          = 24,
  parameter int DECAY_STEP = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic signed [W-1:0] phase_err_i,
  input logic                locked_i,
  input logic                pbo_en_i,
  input logic                pbo_freeze_i,
  input logic signed [W-1:0] offset_o,
  input logic                capture_o
);
  localparam logic signed [W-1:0] STEP_P = W'(DECAY_STEP);

  a_r2_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> offset_o == $past(phase_err_i));

  a_r3_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pbo_en_i && pbo_freeze_i) |=> $stable(offset_o));

  a_r3_no_capture_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbo_freeze_i |-> ##2 !capture_o);

  a_r5_decay_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pbo_en_i && locked_i && offset_o > STEP_P) |=> offset_o == $past(offset_o) - STEP_P);

  a_r6_unlock_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pbo_en_i && !locked_i) |=> offset_o == '0);
endmodule

bind pbo_ctrl pbo_ctrl_chk #(.W(W), .DECAY_STEP(DECAY_STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_err_i (phase_err_i),
  .locked_i    (locked_i),
  .pbo_en_i    (pbo_en_i),
  .pbo_freeze_i(pbo_freeze_i),
  .offset_o    (offset_o),
  .capture_o   (capture_o)
);

// File: tb/pbo_ctrl_tb.sv
`timescale 1ns/1ps
module pbo_ctrl_tb;
  localparam int DSTEP = 64;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [23:0] phase_err = '0;
  logic sw = 1'b0, lk = 1'b0, en = 1'b0, fz = 1'b0;
  logic signed [4:0]  st = '0;
  logic signed [15:0] fine = '0;
  logic signed [23:0] corr, off;
  logic cap;

  int checks = 0;
  int errors = 0;

  longint m_off = 0, m_corr = 0;
  logic m_en_q = 1'b0, m_pend = 1'b0, m_cap = 1'b0;

  always #2 clk = ~clk;

  pbo_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_err_i(phase_err), .switch_evt_i(sw),
    .locked_i(lk), .pbo_en_i(en), .pbo_freeze_i(fz), .static_ofs_i(st),
    .fine_adj_i(fine), .corr_err_o(corr), .offset_o(off), .capture_o(cap)
  );

  function automatic longint sat24(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint clamp14(longint v);
    if (v > 14) return 14;
    if (v < -14) return -14;
    return v;
  endfunction

  function automatic longint to_zero(longint v);
    if (v > DSTEP) return v - DSTEP;
    if (v < -DSTEP) return v + DSTEP;
    return 0;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic e, logic l, logic f, logic s, longint err, int stc, int fc);
    longint term, n_off, n_corr;
    logic n_pend, n_cap;
    string t_off, t_corr;
    en = e; lk = l; fz = f; sw = s;
    phase_err = 24'(err); st = 5'(stc); fine = 16'(fc);
    n_pend = !f && ((s && e) || (e && !m_en_q && l));
    if (!e) n_off = l ? to_zero(m_off) : 0;
    else if (m_pend && !f) n_off = err;
    else n_off = m_off;
    n_cap = e && m_pend && !f;
    term = e ? clamp14(longint'(stc)) * 101 : (f ? 0 : longint'(fc) * 6);
    n_corr = sat24(err - m_off + term);
    t_off = !e ? (l ? "R5" : "R6") : (f ? "R3" : "R2");
    t_corr = (n_corr != err - m_off + term) ? "R10" :
             (!e ? "R9" : ((stc > 14 || stc < -14) ? "R8" : "R7"));
    @(posedge clk);
    #1;
    m_off = n_off; m_corr = n_corr; m_pend = n_pend; m_cap = n_cap; m_en_q = e;
    chk(t_off, longint'(off), m_off);
    chk(t_corr, longint'(corr), m_corr);
    chk("R2 capture pulse", longint'(cap), longint'(m_cap));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sd;
    logic re, rl, rf;
    sd = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset offset", longint'(off), 0);
    chk("R1 reset corr", longint'(corr), 0);
    chk("R1 reset capture", longint'(cap), 0);
    rst_n = 1'b1;

    // directed: idle, enable while unlocked gives no capture
    step(0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 500, 0, 0);
    step(1, 0, 0, 0, 500, 0, 0);
    step(1, 0, 0, 0, 500, 0, 0);
    chk("R4 no capture unlocked", longint'(off), 0);
    // switch event: capture uses the sample of the following cycle
    step(1, 1, 0, 1, 500, 0, 0);
    step(1, 1, 0, 0, 777, 0, 0);
    chk("R2 captured value", longint'(off), 777);
    chk("R2 capture flag", longint'(cap), 1);
    step(1, 1, 0, 0, 777, 0, 0);
    chk("R2 pulse one cycle", longint'(cap), 0);
    // freeze blocks events
    step(1, 1, 1, 1, 999, 0, 0);
    step(1, 1, 1, 0, 999, 0, 0);
    step(1, 1, 1, 0, 999, 0, 0);
    chk("R3 frozen offset", longint'(off), 777);
    // disable while locked: stepped decay
    step(0, 1, 0, 0, 0, 0, 0);
    chk("R5 decay step", longint'(off), 777 - DSTEP);
    // enable while locked triggers capture
    step(1, 1, 0, 0, 3000, 0, 0);
    step(1, 1, 0, 0, 3000, 0, 0);
    chk("R4 capture on enable", longint'(off), 3000);
    // static code -16 clamps to -14
    step(1, 1, 0, 0, 3000, -16, 0);
    chk("R8 static clamp", longint'(corr), -1414);
    // disable unlocked clears, fine trim applies
    step(0, 0, 0, 0, 0, 0, 1000);
    chk("R6 clear", longint'(off), 0);
    step(0, 0, 0, 0, 0, 0, 1000);
    chk("R9 fine applied", longint'(corr), 6000);
    step(0, 0, 1, 0, 0, 0, 1000);
    chk("R9 fine ignored frozen", longint'(corr), 0);
    step(0, 0, 0, 0, MAXV, 0, 32767);
    chk("R10 positive rail", longint'(corr), MAXV);
    step(0, 0, 0, 0, MINV, 0, -32768);
    chk("R10 negative rail", longint'(corr), MINV);

    // constrained random
    re = 1'b1; rl = 1'b1; rf = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      longint err;
      if ($urandom_range(19) == 0) re = ~re;
      if ($urandom_range(29) == 0) rl = ~rl;
      if ($urandom_range(24) == 0) rf = ~rf;
      if ($urandom_range(15) == 0)
        err = ($urandom_range(1) != 0) ? MAXV - longint'($urandom_range(100)) : MINV + longint'($urandom_range(100));
      else
        err = longint'($urandom_range(20000)) - 10000;
      step(re, rl, rf, $urandom_range(7) == 0, err,
           int'($urandom_range(31)) - 16, int'($urandom_range(65535)) - 32768);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule